// File: doc/BRIEF.md
# Synchronous Serial Clock Output Generator

This block produces the clock pin waveform that a USART drives in synchronous mode. A half-bit tick (two per bit period) paces each frame. A frame is one start bit, 8 or 9 data bits sent least significant bit first, and a parameterised number of stop bits. During data bits the block outputs one clock pulse per bit cell, aligned to the data. It also raises a one-cycle strobe on each edge at which the receiver captures a bit. The clock rests at a selectable idle level during the start bit, during the stop bits and between frames.

Four settings are latched from configuration inputs, and only while the peripheral enable is low:

- **Idle level.** The level the clock rests at outside data bits.
- **Capture phase.** Selects whether the first or the second edge of each bit cell captures the bit.
- **Full count.** When clear, the pulse for the final data bit is left out and that bit still takes its full time.
- **Nine-bit frame.** Selects 9 data bits instead of 8.

A start-of-frame request starts a frame when the block is enabled and idle. `busy` stays high until the last stop bit ends.

Top module: `sync_ck_gen`

## Requirements
- R1: After reset, `busy` is 0, `sample_stb` is 0 and `ck_out` is 0, because the latched idle level resets to 0.
- R2: When `sof` is high in a cycle where `enable` is 1 and `busy` is 0, `busy` is 1 from the next cycle. A frame lasts 1 start bit, N data bits (N = 8, or 9 when the nine-bit setting is 1) and STOP_BITS stop bits. Each bit takes two `tick2x` pulses, and `busy` falls in the cycle after the final tick of the frame.
- R3: `ck_out` equals the latched idle level while not busy, during the start bit, during the stop bits and during any unpulsed data bit. While busy it changes only in the cycle after a `tick2x` pulse.
- R4: With capture phase 0, `ck_out` is at the active level (the inverse of idle) in the second half of each pulsed data cell. The first edge, at mid-cell, is the capture edge.
- R5: With capture phase 1, `ck_out` is at the active level in the first half of each pulsed data cell. The second edge, at mid-cell, is the capture edge.
- R6: With full count 1, every data bit gets one pulse: 8 pulses for an 8-bit frame and 9 for a 9-bit frame.
- R7: With full count 0, the final data bit gets no pulse, which gives 7 or 8 pulses per frame. The frame length is unchanged.
- R8: `sample_stb` is high for exactly one cycle, in the same cycle as each capture edge, and only for pulsed data bits. In that cycle `ck_out` equals idle XOR (NOT phase).
- R9: The configuration inputs are latched only while `cfg_we` is 1 and `enable` is 0. A `cfg_we` while enabled has no effect.
- R10: `sof` is ignored while `busy` is 1 or `enable` is 0.
- R11: Taking `enable` low ends any frame: `busy` is 0 and `ck_out` is at the idle level from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; freezes the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idle | input | 1 | Clock idle level |
| cfg_phase | input | 1 | Capture edge select (0 first, 1 second) |
| cfg_full | input | 1 | 1: pulse for every data bit; 0: no pulse on last data bit |
| cfg_nine | input | 1 | 1: 9 data bits; 0: 8 data bits |
| tick2x | input | 1 | Half-bit-period tick |
| sof | input | 1 | Start-of-frame request |
| busy | output | 1 | Frame in progress |
| ck_out | output | 1 | Serial clock output |
| sample_stb | output | 1 | One-cycle strobe on each capture edge |

## Verification
The bench sweeps all sixteen combinations of idle level, capture phase, full count and frame length. The half-bit tick arrives every third clock, and every output is compared against a cycle-exact model in every cycle. The idle-level sweep exposes inverted polarity. The phase sweep shows whether the active half of each cell and the strobe position are correct. The count and length sweeps show whether the pulse for the final bit is dropped or moved while the frame length holds. In half the runs a conflicting configuration write is held through the frame and a second start request arrives mid-frame, which checks that both are ignored. Separate cases check a start request while disabled and an abort by dropping `enable`.

// File: rtl/sync_ck_gen.sv
module sync_ck_gen #(
  parameter int DATA_SHORT = 8,
  parameter int STOP_BITS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cfg_we,
  input  logic cfg_idle,
  input  logic cfg_phase,
  input  logic cfg_full,
  input  logic cfg_nine,
  input  logic tick2x,
  input  logic sof,
  output logic busy,
  output logic ck_out,
  output logic sample_stb
);
  localparam int MAX_BITS = DATA_SHORT + 2 + STOP_BITS;
  localparam int IW = $clog2(MAX_BITS + 1);

  logic idle_q, phase_q, full_q, nine_q;
  logic busy_q, half_q, stb_q;
  logic [IW-1:0] bit_q;

  wire [IW-1:0] ndata    = nine_q ? IW'(DATA_SHORT + 1) : IW'(DATA_SHORT);
  wire [IW-1:0] last_bit = ndata + IW'(STOP_BITS);
  wire in_data = busy_q && (bit_q != '0) && (bit_q <= ndata);
  wire pulsed  = in_data && (full_q || (bit_q != ndata));
  wire ck_act  = pulsed && (half_q != phase_q);

  assign ck_out     = idle_q ^ ck_act;
  assign busy       = busy_q;
  assign sample_stb = stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      phase_q <= 1'b0;
      full_q  <= 1'b0;
      nine_q  <= 1'b0;
      busy_q  <= 1'b0;
      half_q  <= 1'b0;
      stb_q   <= 1'b0;
      bit_q   <= '0;
    end else begin
      if (cfg_we && !enable) begin
        idle_q  <= cfg_idle;
        phase_q <= cfg_phase;
        full_q  <= cfg_full;
        nine_q  <= cfg_nine;
      end
      stb_q <= 1'b0;
      if (!enable) begin
        busy_q <= 1'b0;
        half_q <= 1'b0;
        bit_q  <= '0;
      end else if (!busy_q) begin
        if (sof) begin
          busy_q <= 1'b1;
          half_q <= 1'b0;
          bit_q  <= '0;
        end
      end else if (tick2x) begin
        half_q <= ~half_q;
        if (!half_q)
          stb_q <= pulsed;
        else if (bit_q == last_bit)
          busy_q <= 1'b0;
        else
          bit_q <= bit_q + 1'b1;
      end
    end
  end

  // R8
  stb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> busy_q);

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R4 R5
  stb_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (ck_out == (idle_q ^ ~phase_q)));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(sof && enable));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable({idle_q, phase_q, full_q, nine_q}));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (!busy_q && ck_out == idle_q));

  // R3
  ck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(tick2x)) |-> $stable(ck_out));
endmodule

// File: tb/sync_ck_gen_tb_top.sv
module sync_ck_gen_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, cfg_we = 1'b0;
  logic cfg_idle = 1'b0, cfg_phase = 1'b0, cfg_full = 1'b0, cfg_nine = 1'b0;
  logic tick2x = 1'b0, sof = 1'b0;
  logic busy, ck_out, sample_stb;
  int checks = 0, fails = 0;

  sync_ck_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_idle(cfg_idle), .cfg_phase(cfg_phase), .cfg_full(cfg_full),
    .cfg_nine(cfg_nine), .tick2x(tick2x), .sof(sof),
    .busy(busy), .ck_out(ck_out), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pulsed_bit(input int b, input int n, input bit fl);
    return (b >= 1) && (b <= n) && (fl || b != n);
  endfunction

  task automatic configure(input bit idl, input bit ph, input bit fl, input bit nn);
    @(negedge clk);
    enable = 1'b0; cfg_we = 1'b1;
    cfg_idle = idl; cfg_phase = ph; cfg_full = fl; cfg_nine = nn;
    @(negedge clk);
    cfg_we = 1'b0; enable = 1'b1;
  endtask

  task automatic run_frame(input bit idl, input bit ph, input bit fl, input bit nn, input bit hostile);
    int n, total, t, b, pulses, strobes;
    bit tk, exp_stb, exp_busy, exp_ck, prev_ck;
    string ckreq;
    configure(idl, ph, fl, nn);
    if (hostile) begin
      // R9: conflicting write held while enabled
      cfg_we = 1'b1;
      cfg_idle = ~idl; cfg_phase = ~ph; cfg_full = ~fl; cfg_nine = ~nn;
    end
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    n = nn ? 9 : 8;
    total = 2 * (n + 2);
    t = 0; pulses = 0; strobes = 0; prev_ck = idl;
    chk(busy == 1'b1, "R2 busy after sof", busy, 1);
    chk(ck_out == idl, "R3 start bit idle", ck_out, idl);
    for (int c = 0; c < total * 3 + 6; c++) begin
      tk = (c % 3 == 2);
      tick2x = tk;
      sof = (c == 4);  // R10: sof during busy
      @(negedge clk);
      exp_stb = tk && (t < total) && (t % 2 == 0) && pulsed_bit(t / 2, n, fl);
      if (tk && t < total) t++;
      exp_busy = (t < total);
      b = t / 2;
      exp_ck = idl ^ (exp_busy && pulsed_bit(b, n, fl) && ((t % 2) != ph));
      ckreq = (exp_busy && b >= 1 && b <= n) ? (ph ? "R5 ck level" : "R4 ck level") : "R3 ck idle";
      chk(busy == exp_busy, hostile ? "R2 R10 busy" : "R2 busy", busy, exp_busy);
      chk(ck_out == exp_ck, ckreq, ck_out, exp_ck);
      chk(sample_stb == exp_stb, "R8 strobe", sample_stb, exp_stb);
      if (ck_out != prev_ck && ck_out != idl) pulses++;
      prev_ck = ck_out;
      if (sample_stb) strobes++;
    end
    tick2x = 1'b0; sof = 1'b0; cfg_we = 1'b0;
    chk(pulses == n - 1 + int'(fl), fl ? "R6 R9 pulse count" : "R7 R9 pulse count", pulses, n - 1 + int'(fl));
    chk(strobes == n - 1 + int'(fl), "R8 strobe count", strobes, n - 1 + int'(fl));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(ck_out == 1'b0, "R1 ck reset", ck_out, 0);
    chk(sample_stb == 1'b0, "R1 strobe reset", sample_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++)
      run_frame(i[0], i[1], i[2], i[3], i[0] ^ i[1]);

    // R10: sof while disabled is ignored
    configure(1'b1, 1'b0, 1'b1, 1'b0);
    enable = 1'b0; sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 sof while disabled", busy, 0);
    chk(ck_out == 1'b1, "R10 idle held", ck_out, 1);

    // R11: abort mid-frame
    enable = 1'b1; sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    for (int k = 0; k < 7; k++) begin
      tick2x = 1'b1;
      @(negedge clk);
    end
    tick2x = 1'b0;
    chk(busy == 1'b1, "R11 busy before abort", busy, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy after abort", busy, 0);
    chk(ck_out == 1'b1, "R11 ck idle after abort", ck_out, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule